// File: doc/BRIEF.md
# Bidirectional multiplexed latching bus transceiver

This block lets two 12-bit data paths share one 12-bit bus in either direction. It is typically used to split or merge address and data words, or to interleave two memory banks. Port A is the shared side. Ports 1B and 2B are the two banked sides. Every pin is modelled as a data-in vector, a data-out vector and a per-bit drive-enable vector. A pad ring or a bus fabric resolves these into real tri-state wires.

The return path carries data from the B ports to port A. Each B port feeds its own storage latch, and a select input picks which of the two latch views drives port A. The forward path carries data from port A to the B ports. Port A feeds two independent latches, one for each B port, so one A word can be parked in either bank or in both.

Each latch is transparent while its enable is high, and it keeps the word it last saw when the enable drops. Each port has its own active-low output enable. An asynchronous active-low reset clears all four latches and turns every driver off.

Top module: `mux_latch_xcvr`

## Requirements
- R1: While a forward enable (`le_fwd1` for 1B, `le_fwd2` for 2B) is high, that B output follows `a_in` in the same cycle, with no clock latency.
- R2: After a forward enable goes low, its B output shows the `a_in` value that was present at the last rising clock edge at which the enable was high.
- R3: While a forward enable stays low, its B output does not change, whatever `a_in` does.
- R4: The return latches behave the same way on their own inputs. `le_ret1` makes the 1B latch follow `b1_in`, `le_ret2` makes the 2B latch follow `b2_in`, and each latch holds its last word while its enable is low.
- R5: `a_out` shows the 1B return-latch view when `sel_b1` = 1 and the 2B return-latch view when `sel_b1` = 0. Toggling `sel_b1` while both latches are closed switches between the two held words and leaves both words unchanged.
- R6: The two forward latches load independently. Opening only one enable leaves the other bank's held word untouched, and opening both loads the same A word into both banks.
- R7: Every bit of `a_oe` is 1 exactly when `oe_a_n` = 0 and reset is released, and 0 otherwise. Port A and a B port are not meant to drive in the same cycle: the environment keeps `oe_a_n` high whenever `oe_b1_n` or `oe_b2_n` is low.
- R8: All bits of `b1_oe` are 1 exactly when `oe_b1_n` = 0, and all bits of `b2_oe` are 1 exactly when `oe_b2_n` = 0, outside reset. The two enables are independent, and all four combinations are legal.
- R9: While `rst_n` = 0, all drive-enable bits are 0 regardless of the enable inputs. The reset also clears all four latches, so once reset is released and the enables are low, every data output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at which the latches sample while open |
| rst_n | input | 1 | Asynchronous active-low reset (power-up stand-in) |
| a_in | input | 12 | Data arriving on shared port A |
| b1_in | input | 12 | Data arriving on bank port 1B |
| b2_in | input | 12 | Data arriving on bank port 2B |
| le_fwd1 | input | 1 | Open the A-to-1B latch when high |
| le_fwd2 | input | 1 | Open the A-to-2B latch when high |
| le_ret1 | input | 1 | Open the 1B-to-A latch when high |
| le_ret2 | input | 1 | Open the 2B-to-A latch when high |
| sel_b1 | input | 1 | 1: A shows the 1B return latch; 0: the 2B return latch |
| oe_a_n | input | 1 | Active-low output enable of port A |
| oe_b1_n | input | 1 | Active-low output enable of port 1B |
| oe_b2_n | input | 1 | Active-low output enable of port 2B |
| a_out | output | 12 | Data driven onto port A |
| a_oe | output | 12 | Per-bit drive enable of port A |
| b1_out | output | 12 | Data driven onto port 1B |
| b1_oe | output | 12 | Per-bit drive enable of port 1B |
| b2_out | output | 12 | Data driven onto port 2B |
| b2_oe | output | 12 | Per-bit drive enable of port 2B |

## Verification
The checker assumes that the environment never enables port A while either B port is enabled. This single-direction premise is asserted on the enable inputs, because the block itself does not arbitrate between the two directions. The capture and hold properties also assume that the latch enables and data are steady across each rising edge. The stimulus meets both assumptions: every input changes only on the falling clock edge, and `oe_a_n` is low only in the return-path phase, where both B enables are held high.

// File: rtl/mux_latch_xcvr_pkg.sv
package mux_latch_xcvr_pkg;

  typedef enum logic {
    RET_FROM_B2 = 1'b0,
    RET_FROM_B1 = 1'b1
  } ret_src_e;

  // One drive-enable bit: on only outside reset with the active-low enable asserted.
  function automatic logic drive_on(input logic rst_n, input logic oe_n);
    return rst_n & ~oe_n;
  endfunction

  // View of a level-sensitive storage element: live input while open.
  function automatic logic pick_view(input logic open_en, input logic live, input logic held);
    return open_en ? live : held;
  endfunction

endpackage

// File: rtl/xcvr_latch.sv
module xcvr_latch #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] view
);
  import mux_latch_xcvr_pkg::*;

  logic [W-1:0] held_q;
  logic         load_now;

  assign load_now = le;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        held_q <= '0;
    else if (load_now) held_q <= d;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign view[i] = pick_view(le, d[i], held_q[i]);
  end
endmodule

// File: rtl/xcvr_return_mux.sv
module xcvr_return_mux #(
  parameter int W = 12
) (
  input  logic         sel_b1,
  input  logic [W-1:0] bank1,
  input  logic [W-1:0] bank2,
  output logic [W-1:0] y
);
  import mux_latch_xcvr_pkg::*;

  ret_src_e src;
  assign src = ret_src_e'(sel_b1);

  always_comb begin
    unique case (src)
      RET_FROM_B1: y = bank1;
      default:     y = bank2;
    endcase
  end
endmodule

// File: rtl/xcvr_port_drive.sv
module xcvr_port_drive #(
  parameter int W = 12
) (
  input  logic         rst_n,
  input  logic         oe_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  import mux_latch_xcvr_pkg::*;

  logic drive_any;
  assign drive_any = drive_on(rst_n, oe_n);
  assign pad_out   = d;
  assign pad_oe    = {W{drive_any}};
endmodule

// File: rtl/mux_latch_xcvr.sv
module mux_latch_xcvr #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b1_in,
  input  logic [W-1:0] b2_in,
  input  logic         le_fwd1,
  input  logic         le_fwd2,
  input  logic         le_ret1,
  input  logic         le_ret2,
  input  logic         sel_b1,
  input  logic         oe_a_n,
  input  logic         oe_b1_n,
  input  logic         oe_b2_n,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b1_out,
  output logic [W-1:0] b1_oe,
  output logic [W-1:0] b2_out,
  output logic [W-1:0] b2_oe
);
  localparam int BANKS = 2;

  logic [BANKS-1:0]        fwd_le, ret_le, bank_oe_n;
  logic [BANKS-1:0][W-1:0] fwd_view, ret_view, ret_din, bank_out, bank_oe;
  logic [W-1:0]            a_data;

  assign fwd_le    = {le_fwd2, le_fwd1};
  assign ret_le    = {le_ret2, le_ret1};
  assign ret_din   = {b2_in, b1_in};
  assign bank_oe_n = {oe_b2_n, oe_b1_n};

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    xcvr_latch #(.W(W)) u_fwd (
      .clk(clk), .rst_n(rst_n), .le(fwd_le[g]), .d(a_in), .view(fwd_view[g])
    );
    xcvr_latch #(.W(W)) u_ret (
      .clk(clk), .rst_n(rst_n), .le(ret_le[g]), .d(ret_din[g]), .view(ret_view[g])
    );
    xcvr_port_drive #(.W(W)) u_drv (
      .rst_n(rst_n), .oe_n(bank_oe_n[g]), .d(fwd_view[g]),
      .pad_out(bank_out[g]), .pad_oe(bank_oe[g])
    );
  end

  xcvr_return_mux #(.W(W)) u_mux (
    .sel_b1(sel_b1), .bank1(ret_view[0]), .bank2(ret_view[1]), .y(a_data)
  );

  xcvr_port_drive #(.W(W)) u_drv_a (
    .rst_n(rst_n), .oe_n(oe_a_n), .d(a_data), .pad_out(a_out), .pad_oe(a_oe)
  );

  assign b1_out = bank_out[0];
  assign b1_oe  = bank_oe[0];
  assign b2_out = bank_out[1];
  assign b2_oe  = bank_oe[1];
endmodule

// File: rtl/mux_latch_xcvr_chk.sv
module mux_latch_xcvr_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b1_in,
  input logic [W-1:0] b2_in,
  input logic         le_fwd1,
  input logic         le_fwd2,
  input logic         le_ret1,
  input logic         le_ret2,
  input logic         sel_b1,
  input logic         oe_a_n,
  input logic         oe_b1_n,
  input logic         oe_b2_n,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b1_out,
  input logic [W-1:0] b1_oe,
  input logic [W-1:0] b2_out,
  input logic [W-1:0] b2_oe
);
  // Set after the first clock edge out of reset, so $past never reaches into reset.
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_fwd1_transparent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    le_fwd1 |-> b1_out == a_in);
  assert_fwd2_transparent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    le_fwd2 |-> b2_out == a_in);
  assert_fwd1_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(le_fwd1) && !le_fwd1) |-> b1_out == $past(a_in));
  assert_fwd2_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !le_fwd2 && !$past(le_fwd2)) |-> $stable(b2_out));
  assert_ret1_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !le_ret1 && !$past(le_ret1) && sel_b1 && $past(sel_b1)) |-> $stable(a_out));
  assert_sel_b1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_b1 && le_ret1) |-> a_out == b1_in);
  assert_sel_b2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_b1 && le_ret2) |-> a_out == b2_in);
  assert_a_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    a_oe == (oe_a_n ? '0 : '1));
  assert_single_direction_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_a_n && (!oe_b1_n || !oe_b2_n)));
  assert_bank_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (b1_oe == (oe_b1_n ? '0 : '1)) && (b2_oe == (oe_b2_n ? '0 : '1)));

  always_comb begin
    if (rst_n == 1'b0) begin
      assert_reset_quiet_R9: assert ((a_oe == '0) && (b1_oe == '0) && (b2_oe == '0));
    end
  end
endmodule

bind mux_latch_xcvr mux_latch_xcvr_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .b1_in(b1_in), .b2_in(b2_in),
  .le_fwd1(le_fwd1), .le_fwd2(le_fwd2), .le_ret1(le_ret1), .le_ret2(le_ret2),
  .sel_b1(sel_b1), .oe_a_n(oe_a_n), .oe_b1_n(oe_b1_n), .oe_b2_n(oe_b2_n),
  .a_out(a_out), .a_oe(a_oe), .b1_out(b1_out), .b1_oe(b1_oe),
  .b2_out(b2_out), .b2_oe(b2_oe)
);

// File: tb/mux_latch_xcvr_tb.sv
module mux_latch_xcvr_tb;
  localparam int W = 12;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic         rst_n;
    logic [W-1:0] a, b1, b2;
    logic         lf1, lf2, lr1, lr2, sel, oea_n, oeb1_n, oeb2_n;
  } stim_t;

  typedef struct {
    string        tag;
    logic [W-1:0] a_out, a_oe, b1_out, b1_oe, b2_out, b2_oe;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a_in, b1_in, b2_in;
  logic le_fwd1, le_fwd2, le_ret1, le_ret2, sel_b1, oe_a_n, oe_b1_n, oe_b2_n;
  logic [W-1:0] a_out, a_oe, b1_out, b1_oe, b2_out, b2_oe;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  exp_t sb_q[$];
  logic [W-1:0] m_f1, m_f2, m_r1, m_r2;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_latch_xcvr #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b1_in(b1_in), .b2_in(b2_in),
    .le_fwd1(le_fwd1), .le_fwd2(le_fwd2), .le_ret1(le_ret1), .le_ret2(le_ret2),
    .sel_b1(sel_b1), .oe_a_n(oe_a_n), .oe_b1_n(oe_b1_n), .oe_b2_n(oe_b2_n),
    .a_out(a_out), .a_oe(a_oe), .b1_out(b1_out), .b1_oe(b1_oe),
    .b2_out(b2_out), .b2_oe(b2_oe)
  );

  function automatic stim_t idle();
    stim_t s;
    s.rst_n = 1'b1; s.a = '0; s.b1 = '0; s.b2 = '0;
    s.lf1 = 0; s.lf2 = 0; s.lr1 = 0; s.lr2 = 0; s.sel = 1'b1;
    s.oea_n = 1'b1; s.oeb1_n = 1'b1; s.oeb2_n = 1'b1;
    return s;
  endfunction

  // Driver: apply at the falling edge, predict, push, then advance the model past the rising edge.
  task automatic step(input stim_t s, input string tag);
    exp_t e;
    logic [W-1:0] r1v, r2v;
    @(negedge clk);
    rst_n = s.rst_n; a_in = s.a; b1_in = s.b1; b2_in = s.b2;
    le_fwd1 = s.lf1; le_fwd2 = s.lf2; le_ret1 = s.lr1; le_ret2 = s.lr2;
    sel_b1 = s.sel; oe_a_n = s.oea_n; oe_b1_n = s.oeb1_n; oe_b2_n = s.oeb2_n;
    if (!s.rst_n) begin m_f1 = '0; m_f2 = '0; m_r1 = '0; m_r2 = '0; end
    e.tag    = tag;
    e.b1_out = s.lf1 ? s.a : m_f1;
    e.b2_out = s.lf2 ? s.a : m_f2;
    r1v      = s.lr1 ? s.b1 : m_r1;
    r2v      = s.lr2 ? s.b2 : m_r2;
    e.a_out  = s.sel ? r1v : r2v;
    e.a_oe   = (s.rst_n && !s.oea_n)  ? '1 : '0;
    e.b1_oe  = (s.rst_n && !s.oeb1_n) ? '1 : '0;
    e.b2_oe  = (s.rst_n && !s.oeb2_n) ? '1 : '0;
    sb_q.push_back(e);
    @(posedge clk);
    #1;
    if (s.rst_n) begin
      if (s.lf1) m_f1 = s.a;
      if (s.lf2) m_f2 = s.a;
      if (s.lr1) m_r1 = s.b1;
      if (s.lr2) m_r2 = s.b2;
    end
  endtask

  // Monitor: a quarter period after each falling edge, pop and compare.
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        tests++;
        if (a_out !== e.a_out || a_oe !== e.a_oe || b1_out !== e.b1_out ||
            b1_oe !== e.b1_oe || b2_out !== e.b2_out || b2_oe !== e.b2_oe) begin
          fails++;
          $display("FAIL %s: got a=%h/%h b1=%h/%h b2=%h/%h exp a=%h/%h b1=%h/%h b2=%h/%h",
                   e.tag, a_out, a_oe, b1_out, b1_oe, b2_out, b2_oe,
                   e.a_out, e.a_oe, e.b1_out, e.b1_oe, e.b2_out, e.b2_oe);
        end
        if (!oe_a_n && ((b1_oe | b2_oe) != '0)) begin
          fails++;
          $display("FAIL R7 single direction: a_oe=%h b1_oe=%h b2_oe=%h exp no overlap",
                   a_oe, b1_oe, b2_oe);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    stim_t s;
    m_f1 = '0; m_f2 = '0; m_r1 = '0; m_r2 = '0;
    rst_n = 1'b0; a_in = '0; b1_in = '0; b2_in = '0;
    le_fwd1 = 0; le_fwd2 = 0; le_ret1 = 0; le_ret2 = 0; sel_b1 = 1;
    oe_a_n = 1; oe_b1_n = 1; oe_b2_n = 1;

    // R9: enables forced off during reset even when requested
    s = idle(); s.rst_n = 0; s.oeb1_n = 0; s.oeb2_n = 0; s.a = 12'hABC; step(s, "R9 reset drives off");
    s = idle(); s.oeb1_n = 0; s.oeb2_n = 0; step(s, "R9 cleared latches");

    // R1 transparency of the 1B forward latch
    s.lf1 = 1; s.a = 12'hA5C; step(s, "R1 fwd1 open");
    s.a = 12'h3F1;           step(s, "R1 fwd1 follows");
    // R2 capture, R3 hold
    s.lf1 = 0; s.a = 12'h777; step(s, "R2 fwd1 captured");
    s.a = 12'h000;           step(s, "R3 fwd1 holds");
    // R6 independent banks
    s.lf2 = 1; s.a = 12'h123; step(s, "R6 fwd2 only");
    s.lf2 = 0; s.a = 12'hFFF; step(s, "R6 fwd2 held, fwd1 untouched");
    s.lf1 = 1; s.lf2 = 1; s.a = 12'h9E7; step(s, "R6 both banks open");
    s.lf1 = 0; s.lf2 = 0; s.a = 12'h001; step(s, "R6 both banks held");
    // R8 all four bank-enable combinations
    for (int k = 0; k < 4; k++) begin
      s.oeb1_n = k[0]; s.oeb2_n = k[1];
      step(s, "R8 bank enable combination");
    end

    // Return path, port A enabled, B ports off (R7 direction rule)
    s = idle(); s.oea_n = 0;
    s.lr1 = 1; s.b1 = 12'h456; s.sel = 1; step(s, "R4 ret1 open to A");
    s.lr2 = 1; s.b2 = 12'hBCD;            step(s, "R4 ret2 open, A on 1B");
    s.lr1 = 0; s.lr2 = 0; s.b1 = 12'h111; s.b2 = 12'h222; step(s, "R4 ret latches hold");
    s.sel = 0; step(s, "R5 select 2B held");
    s.sel = 1; step(s, "R5 select 1B held again");
    s.sel = 0; s.lr2 = 1; s.b2 = 12'h0F0; step(s, "R5 transparent 2B on A");
    s.lr2 = 0; s.b2 = 12'h333; step(s, "R4 ret2 captured");
    s.oea_n = 1; step(s, "R7 A disabled");
    s.oea_n = 0; step(s, "R7 A enabled");

    // R9 mid-run reset clears every latch
    s = idle(); s.rst_n = 0; s.oea_n = 0; step(s, "R9 mid-run reset");
    s = idle(); s.sel = 1; step(s, "R9 A zero after reset");
    s.sel = 0; s.oeb1_n = 0; step(s, "R9 all zero after reset");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule